// File: doc/BRIEF.md
# ADC conversion sequencer controller

This block is the digital control side of a multi-channel sampling converter. Software programs it over a simple register bus. It picks the event that launches a conversion sequence and walks through a range of single-ended inputs or differential pairs. It hands each conversion to an external analog converter, and it latches each returned sample together with a completion flag. Software can also request one extra conversion with its own channel, reference and decimation settings. That request is slotted in between sequence steps.

The analog converter is reached through a start/done handshake. The controller pulses a start strobe and holds the channel, reference and decimation codes steady until the converter answers with a done pulse and a 14-bit sample. The controller zeroes the sample bits that lie below the resolution of the chosen decimation. It then publishes the result as a high byte and a left-aligned low byte.

Register map, 8-bit data: address 0 control (bit 7 completion flag, read only; bit 6 start/running; bits 5:4 trigger select), address 1 sequence setup (bits 7:6 reference, bits 5:4 decimation, bits 3:0 end channel), address 2 extra conversion (same field layout, writing it launches the conversion), address 3 result low, address 4 result high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x30 (trigger select 11, flag 0, not running), the sequence and result registers read 0, and no start strobe is issued.
- R2: With trigger select 11 and no sequence running, writing control bit 6 as 1 starts a sequence; bit 6 reads 1 while the sequence runs and 0 once its last conversion has returned.
- R3: With trigger select 01 a new sequence starts automatically whenever none is running, with no trigger needed, so conversions repeat back to back.
- R4: With trigger select 10 a sequence starts only on a pulse of timer_evt_i, and the start bit is ignored; with trigger select 00 nothing starts a sequence.
- R5: An end channel code of 0 to 7 converts single-ended channels 0, 1, ... up to that code in ascending order, one conversion each.
- R6: An end channel code of 8 to 11 converts differential pair codes 8, 9, ... up to that code in ascending order.
- R7: An end channel code of 12 to 15 performs exactly one conversion on that code.
- R8: While a sequence is running, bits 3:0 of the sequence register read the channel of the current sequence step; otherwise they read the programmed end code.
- R9: Writing the extra-conversion register requests one conversion with that register's channel, reference and decimation fields. If a conversion is in flight, the request is issued as soon as that conversion returns and before the sequence's next step. The register reads back the last value written.
- R10: conv_start_o is a one-cycle pulse, at most one conversion is in flight, conv_chan_o/conv_ref_o/conv_dec_o hold steady until conv_done_i, and a conv_done_i with no conversion in flight has no effect.
- R11: The completion flag (control bit 7) sets on every returned result, stays set when further results arrive unread, and clears on a read of the result-high register; a result arriving in the same cycle as that read keeps it set.
- R12: A result keeps the top 7, 9, 10 or 12 of its 14 bits for decimation code 0, 1, 2 or 3, and the rest are zero; the high register holds result bits 13:6 and the low register holds result bits 5:0 in its bits 7:2, with bits 1:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (read side effects) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| timer_evt_i | input | 1 | Timer compare event pulse |
| conv_start_o | output | 1 | Start strobe to the converter |
| conv_chan_o | output | 4 | Channel code of the conversion in flight |
| conv_ref_o | output | 2 | Reference code of the conversion in flight |
| conv_dec_o | output | 2 | Decimation code of the conversion in flight |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | RES_W | Sample returned with conv_done_i |

## Verification
The assertions watch the handshake and flag rules on every cycle. They check that the start strobe is a single pulse, that the conversion settings hold while busy, and that a pending extra request is issued at the next free slot. They also check that the sequence channel stays inside its single-ended or differential range, that the flag sets on each result and clears on the high-byte read, and that low bits are masked at the coarsest decimation. Some properties only a scenario can show. These are the exact order of issued channels and where the extra conversion falls in it, the behaviour of each trigger mode including the ignored ones, the channel readback during a run, overrun without a read, and a stray done pulse. The bench's scoreboard and register reads cover those.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int REG_W = 8;
  localparam int CH_W  = 4;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_SEQ    = 1;
  localparam int ADDR_EXT    = 2;
  localparam int ADDR_RES_LO = 3;
  localparam int ADDR_RES_HI = 4;

  localparam logic [CH_W-1:0] SE_LAST    = 4'd7;
  localparam logic [CH_W-1:0] DIFF_FIRST = 4'd8;
  localparam logic [CH_W-1:0] DIFF_LAST  = 4'd11;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'b00,
    TRG_FREE  = 2'b01,
    TRG_TIMER = 2'b10,
    TRG_SOFT  = 2'b11
  } trig_e;

  typedef struct packed {
    logic [1:0]      refsel;
    logic [1:0]      dec;
    logic [CH_W-1:0] chan;
  } conv_cfg_t;

  // first channel of a sequence ending at 'last'
  function automatic logic [CH_W-1:0] seq_first(input logic [CH_W-1:0] last);
    if (last <= SE_LAST)        return '0;
    else if (last <= DIFF_LAST) return DIFF_FIRST;
    else                        return last;
  endfunction

  // significant result bits per decimation code
  function automatic int keep_bits(input logic [1:0] dec);
    case (dec)
      2'd0:    return 7;
      2'd1:    return 9;
      2'd2:    return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/adcseq_trigger.sv
module adcseq_trigger
  import adcseq_pkg::*;
(
  input  trig_e trig_sel_i,
  input  logic  timer_evt_i,
  input  logic  sw_start_i,
  input  logic  seq_active_i,
  output logic  start_req_o
);
  always_comb begin
    case (trig_sel_i)
      TRG_FREE:  start_req_o = !seq_active_i;
      TRG_TIMER: start_req_o = timer_evt_i && !seq_active_i;
      TRG_SOFT:  start_req_o = sw_start_i && !seq_active_i;
      default:   start_req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adcseq_sched.sv
module adcseq_sched
  import adcseq_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_req_i,
  input  conv_cfg_t       seq_cfg_i,
  input  logic            ext_wr_i,
  input  conv_cfg_t       ext_cfg_i,
  input  logic            conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic            conv_start_o,
  output conv_cfg_t       conv_cfg_o,
  output logic            seq_active_o,
  output logic [CH_W-1:0] seq_chan_o,
  output logic            res_we_o,
  output logic [RES_W-1:0] res_data_o
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e             st_q;
  logic            seq_act_q, ext_pend_q, infl_ext_q, start_q;
  logic [CH_W-1:0] cur_q, end_q;
  conv_cfg_t       ext_q, out_q, seq_item;
  logic            issue_ext, issue_seq, done;
  logic [RES_W-1:0] keep_mask;
  int              keep_n;

  assign issue_ext = (st_q == ST_IDLE) && ext_pend_q;
  assign issue_seq = (st_q == ST_IDLE) && !ext_pend_q && seq_act_q;
  assign done      = (st_q == ST_BUSY) && conv_done_i;

  always_comb begin
    seq_item        = seq_cfg_i;
    seq_item.chan   = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      start_q    <= 1'b0;
      out_q      <= '0;
      infl_ext_q <= 1'b0;
    end else begin
      start_q <= issue_ext || issue_seq;
      if (issue_ext) begin
        out_q      <= ext_q;
        infl_ext_q <= 1'b1;
        st_q       <= ST_BUSY;
      end else if (issue_seq) begin
        out_q      <= seq_item;
        infl_ext_q <= 1'b0;
        st_q       <= ST_BUSY;
      end else if (done) begin
        st_q <= ST_IDLE;
      end
    end
  end

  // extra request: a new write wins over the clear of the one being issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_pend_q <= 1'b0;
      ext_q      <= '0;
    end else if (ext_wr_i) begin
      ext_pend_q <= 1'b1;
      ext_q      <= ext_cfg_i;
    end else if (issue_ext) begin
      ext_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_act_q <= 1'b0;
      cur_q     <= '0;
      end_q     <= '0;
    end else if (!seq_act_q && start_req_i) begin
      seq_act_q <= 1'b1;
      end_q     <= seq_cfg_i.chan;
      cur_q     <= seq_first(seq_cfg_i.chan);
    end else if (done && !infl_ext_q) begin
      if (cur_q == end_q) seq_act_q <= 1'b0;
      else                cur_q     <= cur_q + 1'b1;
    end
  end

  assign keep_n = keep_bits(out_q.dec);

  for (genvar i = 0; i < RES_W; i++) begin : g_mask
    assign keep_mask[i] = (i >= (RES_W - keep_n));
  end

  assign conv_start_o = start_q;
  assign conv_cfg_o   = out_q;
  assign seq_active_o = seq_act_q;
  assign seq_chan_o   = cur_q;
  assign res_we_o     = done;
  assign res_data_o   = conv_data_i & keep_mask;

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !conv_done_i) |=> $stable(conv_cfg_o));

  p_ext_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_ext |=> (conv_start_o && conv_cfg_o.chan == $past(ext_q.chan)));

  p_se_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_act_q && end_q <= SE_LAST) |-> (cur_q <= end_q));

  p_diff_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_act_q && end_q > SE_LAST && end_q <= DIFF_LAST)
      |-> (cur_q >= DIFF_FIRST && cur_q <= end_q));

  p_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && conv_cfg_o.dec == 2'b00) |-> (res_data_o[RES_W-8:0] == '0));
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              seq_active_i,
  input  logic [CH_W-1:0]   seq_chan_i,
  input  logic              res_we_i,
  input  logic [RES_W-1:0]  res_data_i,
  output trig_e             trig_sel_o,
  output logic              sw_start_o,
  output conv_cfg_t         seq_cfg_o,
  output logic              ext_wr_o,
  output conv_cfg_t         ext_cfg_o
);
  localparam int LO_W  = RES_W - REG_W;
  localparam int PAD_W = REG_W - LO_W;

  trig_e            trig_q;
  conv_cfg_t        seq_q, ext_q;
  logic [RES_W-1:0] res_q;
  logic             eoc_q;
  logic             wr_ctrl, wr_seq, wr_ext, rd_hi;

  assign wr_ctrl = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_seq  = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_SEQ));
  assign wr_ext  = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_EXT));
  assign rd_hi   = bus_re_i && (bus_addr_i == ADDR_W'(ADDR_RES_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= TRG_SOFT;
      seq_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (wr_ctrl) trig_q <= trig_e'(bus_wdata_i[5:4]);
      if (wr_seq)  seq_q  <= conv_cfg_t'(bus_wdata_i);
      if (wr_ext)  ext_q  <= conv_cfg_t'(bus_wdata_i);
    end
  end

  // a fresh result outranks the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      if (res_we_i) res_q <= res_data_i;
      if (res_we_i)   eoc_q <= 1'b1;
      else if (rd_hi) eoc_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(ADDR_CTRL):   bus_rdata_o = {eoc_q, seq_active_i, trig_q, 4'b0000};
      ADDR_W'(ADDR_SEQ):    bus_rdata_o = {seq_q.refsel, seq_q.dec,
                                           seq_active_i ? seq_chan_i : seq_q.chan};
      ADDR_W'(ADDR_EXT):    bus_rdata_o = ext_q;
      ADDR_W'(ADDR_RES_LO): bus_rdata_o = {res_q[LO_W-1:0], {PAD_W{1'b0}}};
      ADDR_W'(ADDR_RES_HI): bus_rdata_o = res_q[RES_W-1 -: REG_W];
      default:              bus_rdata_o = '0;
    endcase
  end

  assign trig_sel_o = trig_q;
  assign sw_start_o = wr_ctrl && bus_wdata_i[6];
  assign seq_cfg_o  = seq_q;
  assign ext_wr_o   = wr_ext;
  assign ext_cfg_o  = conv_cfg_t'(bus_wdata_i);

  p_eoc_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_i |=> eoc_q);

  p_eoc_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && !res_we_i) |=> !eoc_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              timer_evt_i,
  output logic              conv_start_o,
  output logic [3:0]        conv_chan_o,
  output logic [1:0]        conv_ref_o,
  output logic [1:0]        conv_dec_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i
);
  trig_e            trig_sel;
  logic             sw_start, start_req, ext_wr, seq_active, res_we;
  conv_cfg_t        seq_cfg, ext_cfg, conv_cfg;
  logic [CH_W-1:0]  seq_chan;
  logic [RES_W-1:0] res_data;

  adcseq_regs #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_we_i     (bus_we_i),
    .bus_re_i     (bus_re_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .seq_active_i (seq_active),
    .seq_chan_i   (seq_chan),
    .res_we_i     (res_we),
    .res_data_i   (res_data),
    .trig_sel_o   (trig_sel),
    .sw_start_o   (sw_start),
    .seq_cfg_o    (seq_cfg),
    .ext_wr_o     (ext_wr),
    .ext_cfg_o    (ext_cfg)
  );

  adcseq_trigger u_trigger (
    .trig_sel_i   (trig_sel),
    .timer_evt_i  (timer_evt_i),
    .sw_start_i   (sw_start),
    .seq_active_i (seq_active),
    .start_req_o  (start_req)
  );

  adcseq_sched #(.RES_W(RES_W)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_req_i  (start_req),
    .seq_cfg_i    (seq_cfg),
    .ext_wr_i     (ext_wr),
    .ext_cfg_i    (ext_cfg),
    .conv_done_i  (conv_done_i),
    .conv_data_i  (conv_data_i),
    .conv_start_o (conv_start_o),
    .conv_cfg_o   (conv_cfg),
    .seq_active_o (seq_active),
    .seq_chan_o   (seq_chan),
    .res_we_o     (res_we),
    .res_data_o   (res_data)
  );

  assign conv_chan_o = conv_cfg.chan;
  assign conv_ref_o  = conv_cfg.refsel;
  assign conv_dec_o  = conv_cfg.dec;

  p_idle_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !conv_start_o);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        timer_evt_i = 1'b0;
  logic        conv_start_o;
  logic [3:0]  conv_chan_o;
  logic [1:0]  conv_ref_o, conv_dec_o;
  logic        conv_done_i;
  logic [13:0] conv_data_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit strict = 1;
  bit model_busy = 0;
  int start_cnt = 0;
  logic [7:0] last_cfg = '0;
  int spur_req = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .timer_evt_i(timer_evt_i), .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_ref_o(conv_ref_o), .conv_dec_o(conv_dec_o), .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i)
  );

  function automatic logic [13:0] mk_data(input logic [7:0] c);
    return {c[3:0], c[7:6], c[5:4], 6'b101101};
  endfunction

  function automatic logic [13:0] exp_res(input logic [7:0] c);
    int keep;
    case (c[5:4])
      2'd0: keep = 7;
      2'd1: keep = 9;
      2'd2: keep = 10;
      default: keep = 12;
    endcase
    return mk_data(c) & (14'h3FFF << (14 - keep));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and scoreboard monitor
  initial begin
    int lat = 0;
    int spur_ack = 0;
    logic [7:0] cur = '0;
    conv_done_i = 1'b0;
    conv_data_i = '0;
    forever begin
      @(negedge clk_i);
      conv_done_i = 1'b0;
      if (spur_req != spur_ack) begin
        spur_ack = spur_req;
        conv_done_i = 1'b1;
        conv_data_i = 14'h3FFF;
      end else if (model_busy) begin
        if (lat == 0) begin
          conv_done_i = 1'b1;
          conv_data_i = mk_data(cur);
          model_busy = 0;
        end else lat--;
      end
      if (conv_start_o) begin
        cur = {conv_ref_o, conv_dec_o, conv_chan_o};
        last_cfg = cur;
        start_cnt++;
        model_busy = 1;
        lat = 2;
        if (exp_q.size() == 0) begin
          if (strict) begin
            n_chk++; n_bad++;
            $display("FAIL R4 R10 unexpected conversion start: actual=%0h expected=none", cur);
          end
        end else begin
          chk("R5 R6 R7 R9 R3 conversion order", 32'(cur), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_re_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_re_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !model_busy) begin
        bus_addr_i = 3'd0;
        #1;
        if (!bus_rdata_o[6]) break;
      end
    end
    repeat (3) @(negedge clk_i);
  endtask

  task automatic wait_start(input logic [3:0] ch);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      #2;
      if (conv_start_o && last_cfg[3:0] == ch) break;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi_keep, lo_keep;
    logic [13:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    peek(3'd0, d); chk("R1 control after reset", 32'(d), 32'h30);
    peek(3'd1, d); chk("R1 sequence reg after reset", 32'(d), 32'h00);
    peek(3'd4, d); chk("R1 result high after reset", 32'(d), 32'h00);
    chk("R1 no start strobe", 32'(conv_start_o), 32'h0);

    // R2 R5 R8 software-started single-ended sequence 0..3
    wr(3'd1, 8'h73);
    for (int c = 0; c < 4; c++) exp_q.push_back({4'h7, 4'(c)});
    wr(3'd0, 8'h70);
    peek(3'd0, d); chk("R2 running bit set", 32'(d[6]), 32'h1);
    wait_start(4'd2);
    bus_addr_i = 3'd1; #1;
    chk("R8 channel readback while running", 32'(bus_rdata_o[3:0]), 32'h2);
    wait_idle();
    chk("R5 all steps issued", 32'(exp_q.size()), 32'h0);
    peek(3'd0, d); chk("R2 running bit clear", 32'(d[6]), 32'h0);
    chk("R11 flag held after unread results", 32'(d[7]), 32'h1);
    peek(3'd1, d); chk("R8 end code when idle", 32'(d[3:0]), 32'h3);
    r = exp_res(8'h73);
    peek(3'd3, d); chk("R12 low byte dec3", 32'(d), 32'({r[5:0], 2'b00}));
    rd(3'd4, d);   chk("R12 high byte dec3", 32'(d), 32'(r[13:6]));
    peek(3'd0, d); chk("R11 flag cleared by high read", 32'(d[7]), 32'h0);

    // R6 differential 8..10
    wr(3'd1, 8'h2A);
    for (int c = 8; c <= 10; c++) exp_q.push_back({4'h2, 4'(c)});
    wr(3'd0, 8'h70);
    wait_idle();
    chk("R6 all pairs issued", 32'(exp_q.size()), 32'h0);

    // R7 single conversion on code 14, dec 0
    wr(3'd1, 8'h8E);
    exp_q.push_back(8'h8E);
    wr(3'd0, 8'h70);
    wait_idle();
    chk("R7 one conversion", 32'(exp_q.size()), 32'h0);
    r = exp_res(8'h8E);
    peek(3'd3, d); chk("R12 low byte dec0", 32'(d), 32'({r[5:0], 2'b00}));
    rd(3'd4, d);   chk("R12 high byte dec0", 32'(d), 32'(r[13:6]));

    // R4 timer mode ignores start bit, starts on timer pulse
    wr(3'd0, 8'h20);
    wr(3'd0, 8'h60);
    repeat (15) @(negedge clk_i);
    peek(3'd0, d); chk("R4 start bit ignored in timer mode", 32'(d), 32'h20);
    exp_q.push_back(8'h8E);
    @(negedge clk_i); timer_evt_i = 1'b1;
    @(negedge clk_i); timer_evt_i = 1'b0;
    wait_idle();
    chk("R4 timer started sequence", 32'(exp_q.size()), 32'h0);
    wr(3'd0, 8'h40);
    repeat (15) @(negedge clk_i);
    peek(3'd0, d); chk("R4 nothing starts with select 00", 32'(d[6:4]), 32'h0);

    // R3 free-running 0,1,0,1,...
    wr(3'd1, 8'hD1);
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(8'hD0);
      exp_q.push_back(8'hD1);
    end
    wr(3'd0, 8'h10);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk_i);
    strict = 0;
    chk("R3 repeated sequences without trigger", 32'(exp_q.size()), 32'h0);
    wr(3'd0, 8'h30);
    repeat (25) @(negedge clk_i);
    exp_q.delete();
    strict = 1;
    peek(3'd0, d); chk("R3 stops after leaving free mode", 32'(d[6:4]), 32'h3);
    rd(3'd4, d);

    // R9 extra conversion inserted mid-sequence
    wr(3'd1, 8'h32);
    exp_q.push_back(8'h30);
    exp_q.push_back(8'h9C);
    exp_q.push_back(8'h31);
    exp_q.push_back(8'h32);
    wr(3'd0, 8'h70);
    wait_start(4'd0);
    wr(3'd2, 8'h9C);
    wait_idle();
    chk("R9 extra slotted before next step", 32'(exp_q.size()), 32'h0);

    // R9 standalone extra, R12 dec2
    exp_q.push_back(8'h6F);
    wr(3'd2, 8'h6F);
    wait_idle();
    chk("R9 standalone extra issued", 32'(exp_q.size()), 32'h0);
    peek(3'd2, d); chk("R9 extra register readback", 32'(d), 32'h6F);
    r = exp_res(8'h6F);
    peek(3'd3, lo_keep); chk("R12 low byte dec2", 32'(lo_keep), 32'({r[5:0], 2'b00}));
    rd(3'd4, hi_keep);   chk("R12 high byte dec2", 32'(hi_keep), 32'(r[13:6]));

    // R10 stray done while idle
    spur_req++;
    repeat (4) @(negedge clk_i);
    peek(3'd0, d); chk("R10 stray done leaves flag clear", 32'(d[7]), 32'h0);
    peek(3'd4, d); chk("R10 stray done leaves result high", 32'(d), 32'(hi_keep));
    peek(3'd3, d); chk("R10 stray done leaves result low", 32'(d), 32'(lo_keep));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule